// File: doc/BRIEF.md
# Register-Class ALU Execute Unit

This unit executes the register-to-register arithmetic and logic instructions of a 16-bit load/store processor. Each cycle it may receive one instruction word together with the word that follows it in the instruction stream. It decodes the word, picks the two operands from its internal bank of eight registers or from an embedded constant, combines them, optionally turns the result one bit left or right, and writes it back to a register in the same clock edge. Register 7 holds the instruction pointer, so any write that lands there is a jump. Register 6 is the link register.

The processor has no flag register. A conditional instruction runs only when register 0 holds zero. The compare and test operations therefore deposit their result in register 0, so that later instructions can test it. A three-bit short constant covers the values -3 to +3. Its remaining code tells the unit to take the full second operand from the following word. The unit then raises a flag so that the fetch logic can step over that word. A separate write port lets other units, such as memory loads, update the register bank. A read port lets them observe it.

Top module: `alu_exec_unit`

## Requirements
- R1: An instruction whose bit 15 is 1 is not part of this class. It causes no register write, no jump and no immediate flag.
- R2: With bit 15 at 0, bits 14:12 select the operation. Codes 0, 1 and 2 write first-source OR, XOR and AND second-source. Code 3 (move) writes the second source unchanged.
- R3: Code 4 writes first plus second source and code 5 writes first minus second source, both modulo 2^16.
- R4: Bits 6:4 name the first-source register. With bit 3 at 0, bits 2:0 name the second-source register. With bit 3 at 1, codes 000, 001, 010, 011, 101, 110 and 111 give the sign-extended constants 0, 1, 2, 3, -3, -2 and -1.
- R5: With bit 3 at 1 and bits 2:0 at 100, the second source is the following word, and imm_used is 1. This holds even when the instruction is suppressed by R6.
- R6: With bit 7 at 1, the instruction writes only if register 0 equals zero. Otherwise wr_en and jump stay 0.
- R7: Without rotation (bit 11 at 0), bits 10:8 are the destination. With bit 11 at 1, the result is rotated by one place before the write: bit 10 at 0 rotates right, at 1 rotates left. Bits 9:8 then pick destination 0 to 3.
- R8: Code 6 (test) writes first AND second source, and code 7 (compare) writes first minus second source. Both always write register 0, whatever the destination bits say.
- R9: jump is 1 exactly when an executed instruction writes register 7. The new register 7 value equals wr_data.
- R10: ld_en writes ld_data into register ld_addr at the clock edge. If an executed instruction writes the same register in the same cycle, the instruction's value is kept. Writes to different registers both land.
- R11: After reset every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| next_word | input | 16 | Word following the instruction |
| ld_en | input | 1 | External register write enable |
| ld_addr | input | 3 | External write register index |
| ld_data | input | 16 | External write data |
| rd_addr | input | 3 | Observation read index |
| rd_data | output | 16 | Contents of register rd_addr |
| wr_en | output | 1 | Instruction writes a register this cycle |
| wr_addr | output | 3 | Register being written |
| wr_data | output | 16 | Value being written |
| imm_used | output | 1 | Following word was consumed as an operand |
| jump | output | 1 | Write targets the instruction pointer |

## Verification
The escape to the following word and the register-0 condition can both apply to the same instruction. A skipped instruction must still report that it used the next word, or the fetcher would run the operand as code. The bench loads a non-zero value into register 0 and issues conditional instructions that carry the escape code. It expects imm_used high while wr_en and jump stay low. It then clears register 0 and repeats the same words, expecting the write to happen. A second overlap is an external load and an executed write to one register in the same edge. That case is judged by reading the register back afterwards.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned REG_CNT = 8;
  localparam int unsigned RIDX_W  = $clog2(REG_CNT);
  localparam int unsigned SHORT_W = 3;

  // Short-constant code that redirects the second operand to the next word
  localparam logic [SHORT_W-1:0] ESC_CODE = 3'b100;

  typedef enum logic [2:0] {
    OP_OR  = 3'd0,
    OP_XOR = 3'd1,
    OP_AND = 3'd2,
    OP_MOV = 3'd3,
    OP_ADD = 3'd4,
    OP_SUB = 3'd5,
    OP_TST = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic                is_alu;
    alu_op_e             op;
    logic                rot_en;
    logic                rot_left;
    logic [RIDX_W-1:0]   dest;
    logic                cond;
    logic [RIDX_W-1:0]   src_a;
    logic                use_const;
    logic [SHORT_W-1:0]  src_b;
    logic                escape;
  } alu_dec_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output alu_dec_t           dec
);

  logic flag_sink;

  always_comb begin
    dec.is_alu    = ~instr[15];
    dec.op        = alu_op_e'(instr[14:12]);
    dec.rot_en    = instr[11];
    dec.rot_left  = instr[10];
    dec.cond      = instr[7];
    dec.src_a     = instr[6:4];
    dec.use_const = instr[3];
    dec.src_b     = instr[2:0];
    dec.escape    = instr[3] && (instr[2:0] == ESC_CODE);

    // Test and compare always land in register 0; rotate narrows the field
    if (instr[14:13] == 2'b11) begin
      dec.dest = '0;
    end else if (instr[11]) begin
      dec.dest = {1'b0, instr[9:8]};
    end else begin
      dec.dest = instr[10:8];
    end
  end

  assign flag_sink = 1'b0;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic              rot_en,
  input  logic              rot_left,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] rot_r;
  logic [DATA_W-1:0] rot_l;

  always_comb begin
    unique case (op)
      OP_OR:           raw = opa | opb;
      OP_XOR:          raw = opa ^ opb;
      OP_AND, OP_TST:  raw = opa & opb;
      OP_MOV:          raw = opb;
      OP_ADD:          raw = opa + opb;
      OP_SUB, OP_CMP:  raw = opa - opb;
      default:         raw = '0;
    endcase
  end

  assign rot_r  = {raw[0], raw[DATA_W-1:1]};
  assign rot_l  = {raw[DATA_W-2:0], raw[DATA_W-1]};
  assign result = !rot_en ? raw : (rot_left ? rot_l : rot_r);

endmodule

// File: rtl/alu_regfile.sv
module alu_regfile
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [RIDX_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic [RIDX_W-1:0] rc_addr,
  output logic [DATA_W-1:0] rc_data,
  output logic [DATA_W-1:0] r0_data,
  input  logic              ex_we,
  input  logic [RIDX_W-1:0] ex_addr,
  input  logic [DATA_W-1:0] ex_data,
  input  logic              ld_we,
  input  logic [RIDX_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data
);

  logic [DATA_W-1:0] rf [REG_CNT];

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    logic              hit_ex;
    logic              hit_ld;
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      hit_ex = ex_we && (ex_addr == RIDX_W'(i));
      hit_ld = ld_we && (ld_addr == RIDX_W'(i));
      en     = hit_ex || hit_ld;
      d      = hit_ex ? ex_data : ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign rf[i] = q;
  end

  assign ra_data = rf[ra_addr];
  assign rb_data = rf[rb_addr];
  assign rc_data = rf[rc_addr];
  assign r0_data = rf[0];

  // Checker state: remember the last executed write to compare after the edge
  logic              chk_we;
  logic [RIDX_W-1:0] chk_addr;
  logic [DATA_W-1:0] chk_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_we   <= 1'b0;
      chk_addr <= '0;
      chk_data <= '0;
    end else begin
      chk_we   <= ex_we;
      chk_addr <= ex_addr;
      chk_data <= ex_data;
    end
  end

  assert_exec_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_we |-> (rf[chk_addr] == chk_data));

endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [DATA_W-1:0] next_word,
  input  logic              ld_en,
  input  logic [2:0]        ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [2:0]        wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              imm_used,
  output logic              jump
);

  localparam int unsigned EXT_W = DATA_W - SHORT_W;
  localparam logic [RIDX_W-1:0] IP_IDX = RIDX_W'(REG_CNT - 1);

  // Reset: asserted asynchronously, removed on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  alu_dec_t          dec;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] reg_b;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] short_ext;
  logic [DATA_W-1:0] r0_val;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] result;
  logic              cond_ok;
  logic              exec;

  alu_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  alu_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ra_addr (dec.src_a),
    .ra_data (opa),
    .rb_addr (dec.src_b),
    .rb_data (reg_b),
    .rc_addr (rd_addr),
    .rc_data (rd_data),
    .r0_data (r0_val),
    .ex_we   (exec),
    .ex_addr (dec.dest),
    .ex_data (result),
    .ld_we   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data)
  );

  always_comb begin
    short_ext = {{EXT_W{dec.src_b[SHORT_W-1]}}, dec.src_b};
    if (!dec.use_const) begin
      opb = reg_b;
    end else if (dec.escape) begin
      opb = next_word;
    end else begin
      opb = short_ext;
    end
  end

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op       (dec.op),
    .rot_en   (dec.rot_en),
    .rot_left (dec.rot_left),
    .opa      (opa),
    .opb      (opb),
    .raw      (raw),
    .result   (result)
  );

  always_comb begin
    cond_ok  = !dec.cond || (r0_val == '0);
    exec     = instr_valid && dec.is_alu && cond_ok;
    wr_en    = exec;
    wr_addr  = dec.dest;
    wr_data  = result;
    imm_used = instr_valid && dec.is_alu && dec.escape;
    jump     = exec && (dec.dest == IP_IDX);
  end

  assert_other_class_idle_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    instr[15] |-> (!wr_en && !imm_used && !jump));

  assert_skip_no_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && !instr[15] && instr[7] && (r0_val != '0)) |-> (!wr_en && !jump));

  assert_escape_kept_on_skip_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (imm_used && !wr_en) |-> instr[7]);

  assert_flag_ops_to_r0_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (instr[14:13] == 2'b11)) |-> (wr_addr == '0));

  assert_rotate_keeps_bits_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    instr[11] |-> ($countones(result) == $countones(raw)));

  assert_rotate_dest_low_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && instr[11]) |-> (wr_addr[2] == 1'b0));

endmodule

// File: tb/tb_alu_exec_unit.sv
module tb_alu_exec_unit;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr;
  logic [15:0] next_word;
  logic        ld_en;
  logic [2:0]  ld_addr;
  logic [15:0] ld_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        imm_used;
  logic        jump;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] m [8];

  alu_exec_unit #(.DATA_W(16)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .next_word   (next_word),
    .ld_en       (ld_en),
    .ld_addr     (ld_addr),
    .ld_data     (ld_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .imm_used    (imm_used),
    .jump        (jump)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_exec(input logic [15:0] ins, input logic [15:0] nw,
                            output logic we, output logic [2:0] da,
                            output logic [15:0] dv, output logic imm);
    logic [15:0] a, b, r;
    we = 1'b0; da = 3'd0; dv = 16'd0; imm = 1'b0;
    if (!ins[15]) begin
      a = m[ins[6:4]];
      if (!ins[3])                 b = m[ins[2:0]];
      else if (ins[2:0] == 3'b100) b = nw;
      else                         b = {{13{ins[2]}}, ins[2:0]};
      case (ins[14:12])
        3'd0: r = a | b;
        3'd1: r = a ^ b;
        3'd2: r = a & b;
        3'd3: r = b;
        3'd4: r = a + b;
        3'd5: r = a - b;
        3'd6: r = a & b;
        default: r = a - b;
      endcase
      if (ins[11]) r = ins[10] ? {r[14:0], r[15]} : {r[0], r[15:1]};
      if (ins[14:13] == 2'b11) da = 3'd0;
      else if (ins[11])        da = {1'b0, ins[9:8]};
      else                     da = ins[10:8];
      imm = ins[3] && (ins[2:0] == 3'b100);
      we  = !ins[7] || (m[0] == 16'd0);
      dv  = r;
    end
  endtask

  task automatic run(input string tag, input logic [15:0] ins, input logic [15:0] nw);
    logic we, imm;
    logic [2:0] da;
    logic [15:0] dv;
    @(negedge clk);
    instr = ins; next_word = nw; instr_valid = 1'b1;
    #1;
    model_exec(ins, nw, we, da, dv, imm);
    chk({tag, " wr_en"}, {15'd0, wr_en}, {15'd0, we});
    chk({tag, " imm_used"}, {15'd0, imm_used}, {15'd0, imm});
    chk({tag, " jump R9"}, {15'd0, jump}, {15'd0, we && (da == 3'd7)});
    if (we) begin
      chk({tag, " wr_addr"}, {13'd0, wr_addr}, {13'd0, da});
      chk({tag, " wr_data"}, wr_data, dv);
    end
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
    if (we) m[da] = dv;
  endtask

  task automatic load(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk);
    #1;
    ld_en = 1'b0;
    m[a] = d;
  endtask

  task automatic readback(input string tag, input logic [2:0] a);
    rd_addr = a;
    #1;
    chk(tag, rd_data, m[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = 16'd0; next_word = 16'd0;
    ld_en = 1'b0; ld_addr = 3'd0; ld_data = 16'd0; rd_addr = 3'd0;
    for (int i = 0; i < 8; i++) m[i] = 16'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R11: registers cleared by reset
    for (int i = 0; i < 8; i++) readback("R11 reset value", 3'(i));
    chk("R11 idle wr_en", {15'd0, wr_en}, 16'd0);

    // Main sweep: every operation, both operand kinds, every second-source code
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 8; i++) begin
        load(3'(i), 16'((i + 1) * 16'h1357 + p * 16'h7A1F) ^ 16'(p << i));
        readback("R10 load", 3'(i));
      end
      for (int op = 0; op < 8; op++) begin
        for (int k = 0; k < 2; k++) begin
          for (int s = 0; s < 8; s++) begin
            string tag;
            logic [2:0] dst, sa;
            dst = 3'((op * 3 + s + p) % 8);
            sa  = 3'((s + op + p) % 8);
            if (op < 4)      tag = "R2";
            else if (op < 6) tag = "R3";
            else             tag = "R8";
            if (k == 1 && s == 4) tag = {tag, "/R5"};
            else                  tag = {tag, "/R4"};
            if (dst == 3'd7 && op < 6) tag = {tag, "/R9"};
            run(tag, {1'b0, 3'(op), 1'b0, dst, 1'b0, sa, 1'(k), 3'(s)},
                16'hA5C3 ^ 16'(op * 16'h0111 + s * 16'h1010 + p));
          end
        end
      end
    end

    // Rotation in both directions, every operation, short destinations
    for (int op = 0; op < 8; op++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int d = 0; d < 4; d++) begin
          run("R7 rotate", {1'b0, 3'(op), 1'b1, 1'(dir), 2'(d), 1'b0, 3'((op + d) % 8), 1'b0, 3'((d + 5) % 8)}, 16'h0);
        end
      end
    end
    run("R7 rotate left wrap", {1'b0, 3'd3, 1'b1, 1'b1, 2'd2, 1'b0, 3'd0, 1'b1, 3'b100}, 16'h8001);
    run("R7 rotate right wrap", {1'b0, 3'd3, 1'b1, 1'b0, 2'd3, 1'b0, 3'd0, 1'b1, 3'b100}, 16'h8001);

    // Conditional execution combined with the next-word escape
    load(3'd0, 16'h0040);
    for (int op = 0; op < 8; op++) begin
      run("R6/R5 skipped escape", {1'b0, 3'(op), 1'b0, 3'd2, 1'b1, 3'd1, 1'b1, 3'b100}, 16'h1234);
      run("R6 skipped reg", {1'b0, 3'(op), 1'b0, 3'd7, 1'b1, 3'd3, 1'b0, 3'd4}, 16'h0);
    end
    readback("R6 r2 unchanged", 3'd2);
    for (int op = 0; op < 6; op++) begin
      load(3'd0, 16'h0000);
      run("R6/R5 taken escape", {1'b0, 3'(op), 1'b0, 3'd2, 1'b1, 3'd1, 1'b1, 3'b100}, 16'h0F0F + 16'(op));
      readback("R6 r2 written", 3'd2);
    end
    load(3'd0, 16'h0000);
    run("R6/R8 conditional compare", {1'b0, 3'd7, 1'b0, 3'd5, 1'b1, 3'd4, 1'b0, 3'd4}, 16'h0);
    run("R6 zero compare enables", {1'b0, 3'd3, 1'b0, 3'd3, 1'b1, 3'd0, 1'b1, 3'd3}, 16'h0);
    readback("R6 r3 after compare", 3'd3);

    // Other instruction class is ignored
    for (int k = 0; k < 16; k++) begin
      run("R1 other class", 16'h8000 | 16'(k * 16'h0F35), 16'hFFFF);
    end
    for (int i = 0; i < 8; i++) readback("R1 bank intact", 3'(i));

    // Explicit jump through register 7
    run("R9 jump via move", {1'b0, 3'd3, 1'b0, 3'd7, 1'b0, 3'd0, 1'b1, 3'b100}, 16'h0400);
    readback("R9 ip value", 3'd7);
    run("R9 ip add", {1'b0, 3'd4, 1'b0, 3'd7, 1'b0, 3'd7, 1'b1, 3'd2}, 16'h0);
    readback("R9 ip advanced", 3'd7);

    // Load and execute in the same edge
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 3'd3; ld_data = 16'hFFFF;
    instr = {1'b0, 3'd3, 1'b0, 3'd3, 1'b0, 3'd0, 1'b1, 3'd1}; instr_valid = 1'b1;
    @(posedge clk);
    #1;
    ld_en = 1'b0; instr_valid = 1'b0; m[3] = 16'h0001;
    readback("R10 same address exec wins", 3'd3);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 3'd4; ld_data = 16'hBEEF;
    instr = {1'b0, 3'd3, 1'b0, 3'd3, 1'b0, 3'd0, 1'b1, 3'b111}; instr_valid = 1'b1;
    @(posedge clk);
    #1;
    ld_en = 1'b0; instr_valid = 1'b0; m[3] = 16'hFFFF; m[4] = 16'hBEEF;
    readback("R10 split exec", 3'd3);
    readback("R10 split load", 3'd4);

    for (int i = 0; i < 8; i++) readback("R10 final bank", 3'(i));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule